// File: doc/BRIEF.md
# Virtually-Indexed Physically-Tagged L1 Lookup

This block is the tag-lookup front end of a 4-way set-associative L1 data cache of 128 sets with 32-byte lines (16 KB). The set index and byte offset both lie inside the page offset, so they are the same in the virtual and the physical address. The block therefore reads all the tags of a set from the untranslated page offset while the translation is still running. It compares those tags with the physical frame number once the translation strobe arrives.

A request carries only the page-offset bits. If the translation strobe comes in the same cycle, the compare happens in that cycle. Otherwise the set contents are held and the block waits, refusing new requests. A hit returns the way and the 32 bits starting at the byte offset. A miss raises a one-cycle request to the next level for the line address. That level answers with a line fill, which the block writes into an invalid way or into the way named by the set's round-robin pointer.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `miss_req_valid` are 0, and every line is invalid, so the first lookup of any set misses.
- R2: The set index is `req_voff[11:5]` and the byte offset is `req_voff[4:0]`. A lookup hits when a valid way of that set holds a tag equal to `xlat_ppn`. One cycle after the compare cycle, `resp_valid`=1, `resp_hit`=1, `resp_way` gives the way, and `resp_word` gives bytes offset..offset+3 of the line, byte n in bits 8n+7:8n of `fill_line`, with zeros past the end of the line.
- R3: When `xlat_done` is high in the cycle a request is accepted, the response appears on the next cycle and `req_ready` stays 1, so lookups can run one per cycle.
- R4: When a request is accepted without `xlat_done`, `req_ready` is 0 and no response appears until the strobe. Requests presented meanwhile are ignored. The response follows the strobe cycle by one cycle and uses the held index and offset.
- R5: On a miss, `resp_hit`=0, `resp_word`=0, and `miss_req_valid` pulses for one cycle together with `resp_valid`, with `miss_req_addr` = {`xlat_ppn`, index, 5'b0}.
- R6: A fill writes the full 32-byte line with tag `fill_tag` into set `fill_set` and marks it valid. The victim is the lowest-numbered invalid way.
- R7: In a set with all ways valid, the victim is the way given by that set's round-robin pointer. The pointer starts at 0 and advances by one on each such eviction, independently per set.
- R8: A strobe with `xlat_fault`=1 cancels the pending or just-accepted lookup: no response and no miss request, and `req_ready` is 1 on the next cycle.
- R9: A fill to the set of a pending lookup, made before the strobe cycle, is seen by that lookup's compare. A fill in the compare cycle itself is not seen.
- R10: A translation strobe with no request accepted or pending produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_voff | input | 12 | Page-offset bits of the virtual address |
| req_ready | output | 1 | No lookup waiting for translation |
| xlat_done | input | 1 | Translation result strobe |
| xlat_fault | input | 1 | Translation failed (qualifies `xlat_done`) |
| xlat_ppn | input | 20 | Physical frame number |
| fill_valid | input | 1 | Line fill from the next level |
| fill_tag | input | 20 | Tag of the filled line |
| fill_set | input | 7 | Set of the filled line |
| fill_line | input | 256 | Line bytes, byte n at bits 8n+7:8n |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 2 | Hitting way |
| resp_word | output | 32 | Bytes starting at the byte offset |
| miss_req_valid | output | 1 | Miss request to the next level |
| miss_req_addr | output | 32 | Line address of the miss |

## Verification
The tag compare and a line fill can both fall in the same cycle on the same set. The bench provokes this three ways. It fills the waiting set between acceptance and the strobe, and expects a hit on the new line. It fills in the strobe cycle of a waiting lookup, and expects a miss. It accepts, strobes and fills all in one cycle, and expects a miss followed by a hit on the next lookup. Back-to-back immediate lookups are judged from a table walked one per cycle. Victim choice is judged by which way later lookups report.

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 5,
  parameter int WAYS   = 4,
  parameter int WORD_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [IDX_W+OFF_W-1:0]            req_voff,
  output logic                              req_ready,
  input  logic                              xlat_done,
  input  logic                              xlat_fault,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0]     xlat_ppn,
  input  logic                              fill_valid,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0]     fill_tag,
  input  logic [IDX_W-1:0]                  fill_set,
  input  logic [(8<<OFF_W)-1:0]             fill_line,
  output logic                              resp_valid,
  output logic                              resp_hit,
  output logic [$clog2(WAYS)-1:0]           resp_way,
  output logic [WORD_W-1:0]                 resp_word,
  output logic                              miss_req_valid,
  output logic [ADDR_W-1:0]                 miss_req_addr
);
  localparam int SETS   = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 << OFF_W;
  localparam int WAY_W  = $clog2(WAYS);

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] line_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  logic              pend_q;
  logic [IDX_W-1:0]  hidx_q;
  logic [OFF_W-1:0]  hoff_q;
  logic [TAG_W-1:0]  htag_q  [WAYS];
  logic [LINE_W-1:0] hline_q [WAYS];
  logic [WAYS-1:0]   hvld_q;

  wire [IDX_W-1:0] r_idx  = req_voff[OFF_W +: IDX_W];
  wire [OFF_W-1:0] r_off  = req_voff[OFF_W-1:0];
  wire             accept = req_valid & ~pend_q;
  wire             go     = xlat_done & (pend_q | accept);
  wire [IDX_W-1:0] cur_idx = pend_q ? hidx_q : r_idx;
  wire [OFF_W-1:0] cur_off = pend_q ? hoff_q : r_off;

  assign req_ready = ~pend_q;

  logic [TAG_W-1:0]  cur_tag  [WAYS];
  logic [LINE_W-1:0] cur_line [WAYS];
  logic [WAYS-1:0]   cur_vld;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  victim;
  logic              any_inv;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cur_tag[w]  = pend_q ? htag_q[w]  : tag_q[r_idx][w];
      cur_line[w] = pend_q ? hline_q[w] : line_q[r_idx][w];
      cur_vld[w]  = pend_q ? hvld_q[w]  : vld_q[r_idx][w];
      hit_vec[w]  = cur_vld[w] && (cur_tag[w] == xlat_ppn);
    end
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    victim  = rr_q[fill_set];
    any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[fill_set][w]) begin
        victim  = WAY_W'(w);
        any_inv = 1'b1;
      end
  end

  wire [LINE_W-1:0] sel_line = cur_line[hit_way];
  wire [LINE_W-1:0] shifted  = sel_line >> {cur_off, 3'b000};
  wire              hit      = |hit_vec;

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fill_set][victim]  <= fill_tag;
      line_q[fill_set][victim] <= fill_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (fill_valid) begin
      vld_q[fill_set][victim] <= 1'b1;
      if (!any_inv) rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hidx_q <= r_idx;
      hoff_q <= r_off;
      hvld_q <= vld_q[r_idx];
      for (int w = 0; w < WAYS; w++) begin
        htag_q[w]  <= tag_q[r_idx][w];
        hline_q[w] <= line_q[r_idx][w];
      end
    end
    if (fill_valid && (accept || pend_q) && fill_set == cur_idx) begin
      htag_q[victim]  <= fill_tag;
      hline_q[victim] <= fill_line;
      hvld_q[victim]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q         <= 1'b0;
      resp_valid     <= 1'b0;
      resp_hit       <= 1'b0;
      resp_way       <= '0;
      resp_word      <= '0;
      miss_req_valid <= 1'b0;
      miss_req_addr  <= '0;
    end else begin
      if (go)          pend_q <= 1'b0;
      else if (accept) pend_q <= 1'b1;
      resp_valid     <= go & ~xlat_fault;
      resp_hit       <= go & ~xlat_fault & hit;
      resp_way       <= hit ? hit_way : '0;
      resp_word      <= hit ? shifted[WORD_W-1:0] : '0;
      miss_req_valid <= go & ~xlat_fault & ~hit;
      miss_req_addr  <= {xlat_ppn, cur_idx, {OFF_W{1'b0}}};
    end
  end
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
module vipt_l1_lookup_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          xlat_done,
  input logic                          xlat_fault,
  input logic [ADDR_W-IDX_W-OFF_W-1:0] xlat_ppn,
  input logic                          resp_valid,
  input logic                          resp_hit,
  input logic                          miss_req_valid,
  input logic [ADDR_W-1:0]             miss_req_addr
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  p_resp_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(xlat_done && !xlat_fault));

  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> resp_valid);

  p_same_cycle_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xlat_done && !xlat_fault) |=> (resp_valid && req_ready));

  p_enter_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlat_done) |=> (!req_ready && !resp_valid));

  p_stay_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !xlat_done) |=> (!req_ready && !resp_valid));

  p_miss_with_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req_valid |-> (resp_valid && !resp_hit));

  p_miss_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req_valid |-> (miss_req_addr[ADDR_W-1 -: TAG_W] == $past(xlat_ppn)));

  p_fault_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_done && xlat_fault) |=> (!resp_valid && !miss_req_valid && req_ready));

  p_idle_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid && xlat_done) |=> !resp_valid);
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .xlat_done(xlat_done), .xlat_fault(xlat_fault), .xlat_ppn(xlat_ppn),
  .resp_valid(resp_valid), .resp_hit(resp_hit),
  .miss_req_valid(miss_req_valid), .miss_req_addr(miss_req_addr)
);

// File: tb/vipt_l1_lookup_tb.sv
`timescale 1ns/1ps
module vipt_l1_lookup_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [11:0]  req_voff = '0;
  logic         req_ready;
  logic         xlat_done = 1'b0;
  logic         xlat_fault = 1'b0;
  logic [19:0]  xlat_ppn = '0;
  logic         fill_valid = 1'b0;
  logic [19:0]  fill_tag = '0;
  logic [6:0]   fill_set = '0;
  logic [255:0] fill_line = '0;
  logic         resp_valid, resp_hit, miss_req_valid;
  logic [1:0]   resp_way;
  logic [31:0]  resp_word;
  logic [31:0]  miss_req_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vipt_l1_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_voff(req_voff),
    .req_ready(req_ready), .xlat_done(xlat_done), .xlat_fault(xlat_fault),
    .xlat_ppn(xlat_ppn), .fill_valid(fill_valid), .fill_tag(fill_tag),
    .fill_set(fill_set), .fill_line(fill_line), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_way(resp_way), .resp_word(resp_word),
    .miss_req_valid(miss_req_valid), .miss_req_addr(miss_req_addr)
  );

  localparam logic [19:0] TA = 20'h1A0A1, TB = 20'h2B0B2, TC = 20'h3C0C3, TD = 20'h4D0D4;
  localparam logic [19:0] TE = 20'h5E0E5, TF = 20'h6F0F6, TG = 20'h7A017, TH = 20'h8A0A8;
  localparam logic [19:0] TJ = 20'h9B0B9, TK = 20'hAC0CA;

  // {voff[11:0], ppn[19:0], hit, way[1:0]}
  localparam logic [34:0] VT [0:7] = '{
    {12'h064, TA, 1'b1, 2'd0},
    {12'h07C, TB, 1'b1, 2'd1},
    {12'h060, TC, 1'b1, 2'd2},
    {12'h070, TD, 1'b1, 2'd3},
    {12'h06C, 20'h0BEEF, 1'b0, 2'd0},
    {12'h088, TA, 1'b1, 2'd0},
    {12'h080, TB, 1'b0, 2'd0},
    {12'h07F, TD, 1'b1, 2'd3}
  };

  function automatic logic [255:0] mkline(input logic [19:0] ppn, input logic [6:0] set);
    logic [255:0] l;
    for (int k = 0; k < 32; k++) l[k*8 +: 8] = ppn[7:0] ^ {set[2:0], 5'(k)};
    return l;
  endfunction

  function automatic logic [31:0] mkword(input logic [19:0] ppn, input logic [11:0] voff);
    logic [255:0] l;
    l = mkline(ppn, voff[11:5]) >> {voff[4:0], 3'b000};
    return l[31:0];
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] tag, input logic [6:0] set);
    fill_valid = 1'b1; fill_tag = tag; fill_set = set; fill_line = mkline(tag, set);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic check_resp(input string req, input logic [11:0] voff, input logic [19:0] ppn,
                            input logic hit, input logic [1:0] way);
    check(req, "resp_valid", 64'(resp_valid), 64'd1);
    check(req, "resp_hit", 64'(resp_hit), 64'(hit));
    check(req, "miss_req_valid", 64'(miss_req_valid), 64'(!hit));
    if (hit) begin
      check(req, "resp_way", 64'(resp_way), 64'(way));
      check(req, "resp_word", 64'(resp_word), 64'(mkword(ppn, voff)));
    end else begin
      check(req, "resp_word", 64'(resp_word), 64'd0);
      check(req, "miss_req_addr", 64'(miss_req_addr), 64'({ppn, voff[11:5], 5'b0}));
    end
  endtask

  task automatic look(input string req, input logic [11:0] voff, input logic [19:0] ppn,
                      input logic hit, input logic [1:0] way);
    req_valid = 1'b1; req_voff = voff; xlat_done = 1'b1; xlat_ppn = ppn;
    @(negedge clk);
    req_valid = 1'b0; xlat_done = 1'b0;
    check_resp(req, voff, ppn, hit, way);
  endtask

  task automatic check_quiet(input string req);
    check(req, "resp_valid", 64'(resp_valid), 64'd0);
    check(req, "miss_req_valid", 64'(miss_req_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and empty cache
    check("R1", "req_ready", 64'(req_ready), 64'd1);
    check_quiet("R1");
    look("R1", 12'h064, TA, 1'b0, 2'd0);

    // R6 fills into lowest invalid way
    fill(TA, 7'd3); fill(TB, 7'd3); fill(TC, 7'd3); fill(TD, 7'd3);
    fill(TA, 7'd4);

    // R2 R3 R5 table, one lookup per cycle
    for (int i = 0; i < 8; i++) begin
      req_valid = 1'b1; xlat_done = 1'b1;
      req_voff = VT[i][34:23]; xlat_ppn = VT[i][22:3];
      @(negedge clk);
      check("R3", "req_ready", 64'(req_ready), 64'd1);
      check_resp(VT[i][2] ? "R2" : "R5", VT[i][34:23], VT[i][22:3], VT[i][2], VT[i][1:0]);
    end
    req_valid = 1'b0; xlat_done = 1'b0;
    @(negedge clk);

    // R7 round robin per set
    fill(TE, 7'd3);
    look("R7", 12'h064, TA, 1'b0, 2'd0);
    look("R7", 12'h064, TE, 1'b1, 2'd0);
    fill(TF, 7'd3);
    look("R7", 12'h068, TF, 1'b1, 2'd1);
    look("R7", 12'h068, TB, 1'b0, 2'd0);
    for (int t = 1; t <= 5; t++) fill(20'h71000 + 20'(t * 16'h0111), 7'd9);
    look("R7", 12'h124, 20'h71555, 1'b1, 2'd0);
    look("R7", 12'h124, 20'h71111, 1'b0, 2'd0);
    look("R7", 12'h124, 20'h71222, 1'b1, 2'd1);
    fill(TG, 7'd3);
    look("R7", 12'h061, TG, 1'b1, 2'd2);
    look("R7", 12'h061, TC, 1'b0, 2'd0);

    // R4 deferred translation, later request ignored
    req_valid = 1'b1; req_voff = 12'h074;
    @(negedge clk);
    req_voff = 12'h060;
    for (int c = 0; c < 2; c++) begin
      check("R4", "req_ready", 64'(req_ready), 64'd0);
      check("R4", "resp_valid", 64'(resp_valid), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0; xlat_done = 1'b1; xlat_ppn = TD;
    @(negedge clk);
    xlat_done = 1'b0;
    check_resp("R4", 12'h074, TD, 1'b1, 2'd3);
    check("R4", "req_ready", 64'(req_ready), 64'd1);

    // R8 fault cancels pending and same-cycle lookups
    req_valid = 1'b1; req_voff = 12'h060;
    @(negedge clk);
    req_valid = 1'b0; xlat_done = 1'b1; xlat_fault = 1'b1; xlat_ppn = TG;
    @(negedge clk);
    xlat_done = 1'b0; xlat_fault = 1'b0;
    check_quiet("R8");
    check("R8", "req_ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_voff = 12'h06C; xlat_done = 1'b1; xlat_fault = 1'b1; xlat_ppn = 20'h0BEEF;
    @(negedge clk);
    req_valid = 1'b0; xlat_done = 1'b0; xlat_fault = 1'b0;
    check_quiet("R8");

    // R10 strobe with nothing accepted
    xlat_done = 1'b1; xlat_ppn = TA;
    @(negedge clk);
    xlat_done = 1'b0;
    check_quiet("R10");

    // R9 fill before strobe is seen
    req_valid = 1'b1; req_voff = 12'h0A4;
    @(negedge clk);
    req_valid = 1'b0;
    fill(TH, 7'd5);
    xlat_done = 1'b1; xlat_ppn = TH;
    @(negedge clk);
    xlat_done = 1'b0;
    check_resp("R9", 12'h0A4, TH, 1'b1, 2'd0);

    // R9 fill in strobe cycle of a waiting lookup is not seen
    req_valid = 1'b1; req_voff = 12'h0E8;
    @(negedge clk);
    req_valid = 1'b0; xlat_done = 1'b1; xlat_ppn = TK;
    fill(TK, 7'd7);
    xlat_done = 1'b0;
    check_resp("R9", 12'h0E8, TK, 1'b0, 2'd0);
    look("R9", 12'h0E8, TK, 1'b1, 2'd0);

    // R9 accept, strobe and fill in one cycle
    req_valid = 1'b1; req_voff = 12'h0C0; xlat_done = 1'b1; xlat_ppn = TJ;
    fill(TJ, 7'd6);
    req_valid = 1'b0; xlat_done = 1'b0;
    check_resp("R9", 12'h0C0, TJ, 1'b0, 2'd0);
    look("R9", 12'h0C3, TJ, 1'b1, 2'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule